// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Bank

This block holds the software-visible control and status words of an Ethernet MAC. Software reaches it over a simple 32-bit, word-addressed bus. The bus has separate write and read strobes, byte enables, write data, registered read data and a registered access-error flag. The MAC datapath reports events through per-register set vectors. The block drives the stored configuration (operating mode, station address, hash filter, VLAN tags, system control, wake-up control, counter control) straight out to the rest of the MAC. It also emits a one-cycle pulse that tells the statistics counters to clear.

Each register has its own write rule:
- Plain registers store the written word.
- Some status words clear the bits written as one, under a per-register mask.
- The live receive and transmit status words ignore writes.
- The counter-control word has a self-clearing reset bit.
- Turning on the receive or transmit enable clears the matching completion bit.

Hardware set requests always win over a software clear in the same cycle.

Top module: `mac_csr`

## Requirements
- R1: After a synchronous reset, the following registers hold these values: address-low (word 1) 0xFFFFFFFF, address-high (word 2) 0x0000FFFF, both VLAN tags (words 5, 6) 0x0000FFFF, system control (word 8) 0x00003F00 and counter control (word 14) 0x0000000A. Every other mapped word reads 0, and bus_err and cnt_clear_o are 0.
- R2: The plain registers store the full written word, read it back unchanged and drive it on their output port. These are mode (word 0), address-low/high (1, 2), hash low/high (3, 4), VLAN A/B (5, 6) and system control (8).
- R3: Mode bit 0 is receive enable and mode bit 16 is transmit enable. A write that takes receive enable from 0 to 1 clears bit 12 (receive done) of the live receive status (word 10). A write that takes transmit enable from 0 to 1 clears bit 1 (transmit done) of the live transmit status (word 12). A write that leaves the enable bit at 1 clears nothing.
- R4: In wake-up control (word 7), the bits under mask 0x00000F20 clear where a one is written. All other bits store the written value.
- R5: In system status (word 9), the bits under mask 0x000000E1 clear where a one is written. Writes leave all other bits unchanged.
- R6: RX sticky (word 11), TX sticky (word 13) and the two counter-interrupt status words (15, 16) clear every bit written as one and keep every bit written as zero.
- R7: Writes to the live receive status (word 10) and live transmit status (word 12) have no effect.
- R8: Writing counter control (word 14) stores bits 31:1, and bit 0 always reads 0. A write with bit 0 set drives cnt_clear_o high for exactly the cycle after the write. A write with bit 0 clear does not.
- R9: The set vectors OR into their registers:
  - rx_set into words 10 and 11
  - tx_set into words 12 and 13
  - sys_set into word 9
  - wake_set (masked by 0x00000F20) into word 7
  - cnt_rx_irq_set into word 15
  - cnt_tx_irq_set into word 16

  A set and a clear of the same bit in one cycle leaves the bit set.
- R10: Reads never change any register.
- R11: Mapped word addresses are 0 to 16. An access to an unmapped word, or with any byte enable low, raises bus_err in the next cycle and writes nothing.
- R12: Read data appears on bus_rdata in the cycle after bus_rd. After an access error, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_be | input | 4 | Byte enables, all must be high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered access-error flag |
| rx_set | input | 32 | Receive status set request |
| tx_set | input | 32 | Transmit status set request |
| sys_set | input | 32 | System status set request |
| wake_set | input | 32 | Wake-up status set request |
| cnt_rx_irq_set | input | 32 | RX counter-interrupt set request |
| cnt_tx_irq_set | input | 32 | TX counter-interrupt set request |
| mode_o | output | 32 | Operating mode |
| addr_lo_o | output | 32 | Station address low word |
| addr_hi_o | output | 32 | Station address high word |
| hash_lo_o | output | 32 | Hash filter low word |
| hash_hi_o | output | 32 | Hash filter high word |
| vlan_a_o | output | 32 | First VLAN tag |
| vlan_b_o | output | 32 | Second VLAN tag |
| sys_ctl_o | output | 32 | System control |
| wake_ctl_o | output | 32 | Wake-up control |
| cnt_ctl_o | output | 32 | Counter control |
| cnt_clear_o | output | 1 | Clear-all-counters pulse |

## Verification
The bench sweeps all 32 word addresses, at reset and after writes of six data patterns:
- The all-ones and all-zeros patterns tell a plain store apart from a write-one-to-clear word.
- The alternating patterns reveal a mask applied to the wrong bits in the wake-up and system status words.
- A pattern that hits exactly the mask bits separates the masked clear from the plain store.

Before each pattern, the set vectors are pulsed so that every clear has bits to remove. Separate sequences then cover:
- enable edges against steady enables
- a set colliding with a clear
- repeated reads of status words
- partial byte enables
- the counter-reset bit with and without bit 0

// File: rtl/mac_csr_pkg.sv
package mac_csr_pkg;

  localparam int DW   = 32;
  localparam int NREG = 17;

  localparam int IX_MODE       = 0;
  localparam int IX_ADDR_LO    = 1;
  localparam int IX_ADDR_HI    = 2;
  localparam int IX_HASH_LO    = 3;
  localparam int IX_HASH_HI    = 4;
  localparam int IX_VLAN_A     = 5;
  localparam int IX_VLAN_B     = 6;
  localparam int IX_WAKE       = 7;
  localparam int IX_SYS_CTL    = 8;
  localparam int IX_SYS_STAT   = 9;
  localparam int IX_RX_STAT    = 10;
  localparam int IX_RX_STKY    = 11;
  localparam int IX_TX_STAT    = 12;
  localparam int IX_TX_STKY    = 13;
  localparam int IX_CNT_CTL    = 14;
  localparam int IX_CNT_RX_IRQ = 15;
  localparam int IX_CNT_TX_IRQ = 16;

  localparam int MODE_RX_EN = 0;
  localparam int MODE_TX_EN = 16;
  localparam int RX_DONE    = 12;
  localparam int TX_DONE    = 1;

  localparam logic [DW-1:0] WAKE_W1C = 32'h0000_0F20;
  localparam logic [DW-1:0] SYS_W1C  = 32'h0000_00E1;

  typedef enum logic [2:0] {
    K_PLAIN,
    K_W1C_KEEP,
    K_W1C,
    K_LIVE,
    K_CNT
  } kind_e;

  function automatic kind_e reg_kind(int idx);
    case (idx)
      IX_WAKE:                    return K_W1C_KEEP;
      IX_SYS_STAT, IX_RX_STKY,
      IX_TX_STKY, IX_CNT_RX_IRQ,
      IX_CNT_TX_IRQ:              return K_W1C;
      IX_RX_STAT, IX_TX_STAT:     return K_LIVE;
      IX_CNT_CTL:                 return K_CNT;
      default:                    return K_PLAIN;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_rst(int idx);
    case (idx)
      IX_ADDR_LO:                        return 32'hFFFF_FFFF;
      IX_ADDR_HI, IX_VLAN_A, IX_VLAN_B:  return 32'h0000_FFFF;
      IX_SYS_CTL:                        return 32'h0000_3F00;
      IX_CNT_CTL:                        return 32'h0000_000A;
      default:                           return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_mask(int idx);
    case (idx)
      IX_WAKE:     return WAKE_W1C;
      IX_SYS_STAT: return SYS_W1C;
      default:     return '1;
    endcase
  endfunction

endpackage

// File: rtl/mac_csr_field.sv
module mac_csr_field #(
  parameter int              DW       = 32,
  parameter logic [DW-1:0]   CLR_MASK = '1,
  parameter bit              KEEP_WR  = 1'b0,
  parameter logic [DW-1:0]   RST_VAL  = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] set_bits,
  input  logic [DW-1:0] clr_bits,
  output logic [DW-1:0] q
);

  logic [DW-1:0] sw_clr;
  logic [DW-1:0] other_n;
  logic [DW-1:0] q_n;

  assign sw_clr = wr_en ? (wdata & CLR_MASK) : '0;

  // Bits outside the clear mask: stored on write, or frozen.
  if (KEEP_WR) begin : g_keep
    assign other_n = wr_en ? (wdata & ~CLR_MASK) : (q & ~CLR_MASK);
  end else begin : g_frozen
    assign other_n = q & ~CLR_MASK;
  end

  // Hardware set is applied last so it wins over any clear.
  assign q_n = other_n | (q & CLR_MASK & ~sw_clr & ~clr_bits) | set_bits;

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= q_n;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (set_bits != '0) |=> ((q & $past(set_bits)) == $past(set_bits)));

  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && set_bits == '0 && clr_bits == '0) |=> $stable(q));

endmodule

// File: rtl/mac_csr_decode.sv
module mac_csr_decode #(
  parameter int ADDR_W = 5,
  parameter int NREG   = 17,
  parameter int DW     = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DW/8-1:0]          be,
  input  logic [NREG-1:0][DW-1:0]  regs,
  output logic [NREG-1:0]          wsel,
  output logic [DW-1:0]            rd_val,
  output logic                     err
);

  logic [NREG-1:0] hit_vec;
  logic            hit;
  logic            full;

  always_comb begin
    hit_vec = '0;
    rd_val  = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == ADDR_W'(i)) begin
        hit_vec[i] = 1'b1;
        rd_val     = regs[i];
      end
    end
  end

  assign hit  = |hit_vec;
  assign full = &be;
  assign err  = (wr || rd) && !(hit && full);
  assign wsel = (wr && full) ? hit_vec : '0;

  assert_onehot_wsel_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wsel));

  assert_err_blocks_write_R11: assert property (@(posedge clk) disable iff (rst)
    err |-> (wsel == '0));

endmodule

// File: rtl/mac_csr.sv
module mac_csr
  import mac_csr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [31:0]       rx_set,
  input  logic [31:0]       tx_set,
  input  logic [31:0]       sys_set,
  input  logic [31:0]       wake_set,
  input  logic [31:0]       cnt_rx_irq_set,
  input  logic [31:0]       cnt_tx_irq_set,
  output logic [31:0]       mode_o,
  output logic [31:0]       addr_lo_o,
  output logic [31:0]       addr_hi_o,
  output logic [31:0]       hash_lo_o,
  output logic [31:0]       hash_hi_o,
  output logic [31:0]       vlan_a_o,
  output logic [31:0]       vlan_b_o,
  output logic [31:0]       sys_ctl_o,
  output logic [31:0]       wake_ctl_o,
  output logic [31:0]       cnt_ctl_o,
  output logic              cnt_clear_o
);

  localparam int BE_W = DW / 8;

  logic [NREG-1:0][DW-1:0] regq;
  logic [NREG-1:0]         wsel;
  logic [DW-1:0]           rd_val;
  logic                    dec_err;
  logic                    rx_rise;
  logic                    tx_rise;
  logic [DW-1:0]           rx_edge_clr;
  logic [DW-1:0]           tx_edge_clr;
  logic                    cnt_clear_q;

  mac_csr_decode #(
    .ADDR_W (ADDR_W),
    .NREG   (NREG),
    .DW     (DW)
  ) u_dec (
    .clk    (clk),
    .rst    (rst),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .addr   (bus_addr),
    .be     (bus_be[BE_W-1:0]),
    .regs   (regq),
    .wsel   (wsel),
    .rd_val (rd_val),
    .err    (dec_err)
  );

  // Enable edges seen by an accepted write to the mode word.
  assign rx_rise = wsel[IX_MODE] && bus_wdata[MODE_RX_EN] && !regq[IX_MODE][MODE_RX_EN];
  assign tx_rise = wsel[IX_MODE] && bus_wdata[MODE_TX_EN] && !regq[IX_MODE][MODE_TX_EN];
  assign rx_edge_clr = rx_rise ? (DW'(1) << RX_DONE) : '0;
  assign tx_edge_clr = tx_rise ? (DW'(1) << TX_DONE) : '0;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam kind_e K = reg_kind(i);
    if (K == K_PLAIN) begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)          regq[i] <= reg_rst(i);
        else if (wsel[i]) regq[i] <= bus_wdata;
      end
    end else if (K == K_CNT) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst) begin
          regq[i]     <= reg_rst(i);
          cnt_clear_q <= 1'b0;
        end else begin
          cnt_clear_q <= wsel[i] && bus_wdata[0];
          if (wsel[i]) regq[i] <= {bus_wdata[DW-1:1], 1'b0};
        end
      end
    end else begin : g_fld
      logic [DW-1:0] s_i;
      logic [DW-1:0] c_i;
      always_comb begin
        case (i)
          IX_RX_STAT, IX_RX_STKY: s_i = rx_set;
          IX_TX_STAT, IX_TX_STKY: s_i = tx_set;
          IX_SYS_STAT:            s_i = sys_set;
          IX_WAKE:                s_i = wake_set & WAKE_W1C;
          IX_CNT_RX_IRQ:          s_i = cnt_rx_irq_set;
          IX_CNT_TX_IRQ:          s_i = cnt_tx_irq_set;
          default:                s_i = '0;
        endcase
        case (i)
          IX_RX_STAT: c_i = rx_edge_clr;
          IX_TX_STAT: c_i = tx_edge_clr;
          default:    c_i = '0;
        endcase
      end
      mac_csr_field #(
        .DW       (DW),
        .CLR_MASK (reg_mask(i)),
        .KEEP_WR  (K == K_W1C_KEEP),
        .RST_VAL  (reg_rst(i))
      ) u_fld (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wsel[i] && (K != K_LIVE)),
        .wdata    (bus_wdata),
        .set_bits (s_i),
        .clr_bits (c_i),
        .q        (regq[i])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= dec_err;
      if (dec_err)     bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_val;
    end
  end

  assign mode_o      = regq[IX_MODE];
  assign addr_lo_o   = regq[IX_ADDR_LO];
  assign addr_hi_o   = regq[IX_ADDR_HI];
  assign hash_lo_o   = regq[IX_HASH_LO];
  assign hash_hi_o   = regq[IX_HASH_HI];
  assign vlan_a_o    = regq[IX_VLAN_A];
  assign vlan_b_o    = regq[IX_VLAN_B];
  assign sys_ctl_o   = regq[IX_SYS_CTL];
  assign wake_ctl_o  = regq[IX_WAKE];
  assign cnt_ctl_o   = regq[IX_CNT_CTL];
  assign cnt_clear_o = cnt_clear_q;

  assert_rx_edge_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(IX_MODE) && (&bus_be) && bus_wdata[MODE_RX_EN]
     && !mode_o[MODE_RX_EN] && !rx_set[RX_DONE]) |=> !regq[IX_RX_STAT][RX_DONE]);

  assert_tx_edge_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(IX_MODE) && (&bus_be) && bus_wdata[MODE_TX_EN]
     && !mode_o[MODE_TX_EN] && !tx_set[TX_DONE]) |=> !regq[IX_TX_STAT][TX_DONE]);

  assert_live_ignores_write_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(IX_RX_STAT) && rx_set == '0) |=> $stable(regq[IX_RX_STAT]));

  assert_cnt_bit0_low_R8: assert property (@(posedge clk) disable iff (rst)
    !cnt_ctl_o[0]);

  assert_cnt_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_clear_o |=> !cnt_clear_o || $past(bus_wr && bus_wdata[0]));

endmodule

// File: tb/tb_mac_csr.sv
`timescale 1ns/1ps
module tb_mac_csr;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [31:0] rx_set = '0, tx_set = '0, sys_set = '0, wake_set = '0;
  logic [31:0] cri_set = '0, cti_set = '0;
  logic [31:0] mode_o, addr_lo_o, addr_hi_o, hash_lo_o, hash_hi_o;
  logic [31:0] vlan_a_o, vlan_b_o, sys_ctl_o, wake_ctl_o, cnt_ctl_o;
  logic        cnt_clear_o;

  always #2 clk = ~clk;

  mac_csr #(.ADDR_W(5)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .rx_set(rx_set), .tx_set(tx_set), .sys_set(sys_set), .wake_set(wake_set),
    .cnt_rx_irq_set(cri_set), .cnt_tx_irq_set(cti_set),
    .mode_o(mode_o), .addr_lo_o(addr_lo_o), .addr_hi_o(addr_hi_o),
    .hash_lo_o(hash_lo_o), .hash_hi_o(hash_hi_o), .vlan_a_o(vlan_a_o),
    .vlan_b_o(vlan_b_o), .sys_ctl_o(sys_ctl_o), .wake_ctl_o(wake_ctl_o),
    .cnt_ctl_o(cnt_ctl_o), .cnt_clear_o(cnt_clear_o)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_r [32];
  logic [31:0] p_rx = '0, p_tx = '0, p_sys = '0, p_wake = '0, p_cri = '0, p_cti = '0;
  logic        last_err, last_clr;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] rst_val(int a);
    case (a)
      1:       return 32'hFFFF_FFFF;
      2, 5, 6: return 32'h0000_FFFF;
      8:       return 32'h0000_3F00;
      14:      return 32'h0000_000A;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(int a);
    case (a)
      0, 1, 2, 3, 4, 5, 6, 8: return "R2";
      7:                      return "R4";
      9:                      return "R5";
      10, 12:                 return "R7";
      11, 13, 15, 16:         return "R6";
      14:                     return "R8";
      default:                return "R11";
    endcase
  endfunction

  function automatic logic [31:0] model_wr(int a, logic [31:0] old, logic [31:0] w);
    case (a)
      7:              return (w & ~32'h0F20) | (old & 32'h0F20 & ~w);
      9:              return (old & ~32'h00E1) | (old & 32'h00E1 & ~w);
      10, 12:         return old;
      11, 13, 15, 16: return old & ~w;
      14:             return w & ~32'h1;
      default:        return w;
    endcase
  endfunction

  task automatic apply_sets_model();
    exp_r[10] |= p_rx;  exp_r[11] |= p_rx;
    exp_r[12] |= p_tx;  exp_r[13] |= p_tx;
    exp_r[9]  |= p_sys;
    exp_r[7]  |= p_wake & 32'h0F20;
    exp_r[15] |= p_cri; exp_r[16] |= p_cti;
  endtask

  task automatic drive_sets(input bit on);
    rx_set   = on ? p_rx   : '0;  tx_set  = on ? p_tx  : '0;
    sys_set  = on ? p_sys  : '0;  wake_set = on ? p_wake : '0;
    cri_set  = on ? p_cri  : '0;  cti_set = on ? p_cti : '0;
  endtask

  task automatic clear_pending();
    p_rx = '0; p_tx = '0; p_sys = '0; p_wake = '0; p_cri = '0; p_cti = '0;
  endtask

  task automatic do_write(input int a, input logic [31:0] w, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = w; bus_be = be;
    drive_sets(1'b1);
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'hF;
    drive_sets(1'b0);
    last_err = bus_err;
    last_clr = cnt_clear_o;
    if (be == 4'hF && a < 17) begin
      if (a == 0) begin
        if (!exp_r[0][0] && w[0])   exp_r[10][12] = 1'b0;
        if (!exp_r[0][16] && w[16]) exp_r[12][1]  = 1'b0;
      end
      exp_r[a] = model_wr(a, exp_r[a], w);
    end
    apply_sets_model();
    clear_pending();
  endtask

  task automatic pulse_sets();
    @(negedge clk);
    drive_sets(1'b1);
    @(negedge clk);
    drive_sets(1'b0);
    apply_sets_model();
    clear_pending();
  endtask

  task automatic do_read(input int a, input logic [3:0] be,
                         output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 5'(a); bus_be = be;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = 4'hF;
    d = bus_rdata;
    e = bus_err;
  endtask

  task automatic rd_check(input int a, input string tag);
    logic [31:0] d;
    logic        e;
    do_read(a, 4'hF, d, e);
    if (a < 17) begin
      check(e == 1'b0, tag, $sformatf("err on read of word %0d", a), 32'(e), 32'h0);
      check(d == exp_r[a], tag, $sformatf("read word %0d", a), d, exp_r[a]);
    end else begin
      check(e == 1'b1 && d == 32'h0, "R11", $sformatf("unmapped word %0d err/data", a),
            {d[30:0], e}, 32'h1);
    end
  endtask

  logic [31:0] pats [6] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_5A5A,
                            32'h5A5A_A5A5, 32'h0001_0001, 32'h0000_0FE1};
  bit done = 1'b0;

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 32; a++) exp_r[a] = rst_val(a);
    @(negedge clk);
    // R1: reset values at the ports
    check(addr_lo_o == 32'hFFFF_FFFF, "R1", "addr_lo reset", addr_lo_o, 32'hFFFF_FFFF);
    check(addr_hi_o == 32'h0000_FFFF, "R1", "addr_hi reset", addr_hi_o, 32'h0000_FFFF);
    check(vlan_a_o == 32'h0000_FFFF && vlan_b_o == 32'h0000_FFFF, "R1", "vlan reset",
          vlan_a_o, 32'h0000_FFFF);
    check(sys_ctl_o == 32'h0000_3F00, "R1", "sys_ctl reset", sys_ctl_o, 32'h0000_3F00);
    check(cnt_ctl_o == 32'h0000_000A, "R1", "cnt_ctl reset", cnt_ctl_o, 32'h0000_000A);
    check(!bus_err && !cnt_clear_o, "R1", "err/clear idle", {30'h0, bus_err, cnt_clear_o}, 32'h0);
    for (int a = 0; a < 32; a++) rd_check(a, "R1");

    // R9: set vectors into live and sticky words, then read twice (R10)
    p_rx = 32'hFFFF_FFFF; p_tx = 32'hFFFF_FFFF; p_sys = 32'hFFFF_FFFF;
    p_wake = 32'hFFFF_FFFF; p_cri = 32'hFFFF_FFFF; p_cti = 32'hFFFF_FFFF;
    pulse_sets();
    for (int a = 7; a < 17; a++) rd_check(a, "R9");
    for (int a = 7; a < 17; a++) rd_check(a, "R10");

    // Pattern sweeps over every address
    for (int k = 0; k < 6; k++) begin
      p_rx = ~pats[k]; p_tx = pats[k] ^ 32'h0F0F_0F0F; p_sys = 32'hFFFF_FFFF;
      p_wake = 32'hFFFF_FFFF; p_cri = ~pats[k]; p_cti = 32'hFFFF_FFFF;
      pulse_sets();
      for (int a = 0; a < 32; a++) begin
        do_write(a, pats[k], 4'hF);
        check(last_err == (a >= 17), "R11", $sformatf("write err word %0d", a),
              32'(last_err), 32'(a >= 17));
        if (a == 14)
          check(last_clr == pats[k][0], "R8", "clear pulse", 32'(last_clr), 32'(pats[k][0]));
        rd_check(a, req_of(a));
      end
      check(mode_o == exp_r[0] && addr_lo_o == exp_r[1] && addr_hi_o == exp_r[2], "R2",
            "mode/addr outputs", mode_o, exp_r[0]);
      check(hash_lo_o == exp_r[3] && hash_hi_o == exp_r[4] && vlan_a_o == exp_r[5]
            && vlan_b_o == exp_r[6] && sys_ctl_o == exp_r[8], "R2", "hash/vlan/sys outputs",
            hash_lo_o, exp_r[3]);
      check(wake_ctl_o == exp_r[7], "R4", "wake output", wake_ctl_o, exp_r[7]);
    end

    // R3: enable edges
    do_write(0, 32'h0, 4'hF);
    p_rx = 32'h0000_1000; p_tx = 32'h0000_0002;
    pulse_sets();
    do_write(0, 32'h0000_0001, 4'hF);
    rd_check(10, "R3");
    check(exp_r[10][12] == 1'b0, "R3", "model rx done cleared", exp_r[10], 32'h0);
    rd_check(12, "R3");
    do_write(0, 32'h0001_0001, 4'hF);
    rd_check(12, "R3");
    p_rx = 32'h0000_1000; p_tx = 32'h0000_0002;
    pulse_sets();
    do_write(0, 32'h0001_0001, 4'hF);
    rd_check(10, "R3");
    rd_check(12, "R3");

    // R9: set wins over edge clear and over software clear
    do_write(0, 32'h0, 4'hF);
    p_rx = 32'h0000_1000;
    do_write(0, 32'h0000_0001, 4'hF);
    rd_check(10, "R9");
    p_rx = 32'h0000_0020;
    do_write(11, 32'hFFFF_FFFF, 4'hF);
    rd_check(11, "R9");
    p_cti = 32'h8000_0000;
    do_write(16, 32'hFFFF_FFFF, 4'hF);
    rd_check(16, "R9");

    // R7: live status ignores writes
    p_tx = 32'h00FF_00FF;
    pulse_sets();
    do_write(12, 32'hFFFF_FFFF, 4'hF);
    rd_check(12, "R7");

    // R11/R12: partial byte enables and errors
    do_write(1, 32'h0, 4'h3);
    check(last_err == 1'b1, "R11", "partial write err", 32'(last_err), 32'h1);
    rd_check(1, "R11");
    begin
      logic [31:0] d;
      logic        e;
      do_read(1, 4'h7, d, e);
      check(e == 1'b1 && d == 32'h0, "R12", "partial read err/data", d, 32'h0);
      do_read(25, 4'hF, d, e);
      check(e == 1'b1 && d == 32'h0, "R12", "unmapped read data", d, 32'h0);
      do_read(2, 4'hF, d, e);
      check(e == 1'b0 && d == exp_r[2], "R12", "read after error", d, exp_r[2]);
    end

    // R8: counter control
    do_write(14, 32'h0000_0005, 4'hF);
    check(last_clr == 1'b1, "R8", "pulse on bit0", 32'(last_clr), 32'h1);
    @(negedge clk);
    check(cnt_clear_o == 1'b0, "R8", "pulse one cycle", 32'(cnt_clear_o), 32'h0);
    rd_check(14, "R8");
    do_write(14, 32'h0000_0004, 4'hF);
    check(last_clr == 1'b0, "R8", "no pulse without bit0", 32'(last_clr), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule